// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of a dual-slope integrating analogue-to-digital converter. While idle it holds the integrator capacitor discharged and its counter at zero. A start pulse begins a conversion. The integrator is first connected to the unknown input for a fixed interval of 2^N clocks, timed by the block's own counter. The integrator is then switched to the reference of opposite sign, and the counter measures how many clocks the integrator takes to fall back to zero. That count is the result, n = 2^N·Vin/Vref. It does not depend on the clock rate or on the integrator time constant, because both slopes see them equally.

The zero-crossing comparator is asynchronous to the clock, so it passes through a two-stage synchroniser. The synchroniser delay is taken out of the count before the value is latched. When the integrator has not returned to zero within 2^N reference clocks, the phase is aborted and flagged as overrange. A one-cycle done pulse marks every new latched result. Start requests that arrive during a conversion are ignored.

Top module: `dual_slope_ctrl`

## Requirements
- R1: After reset, the block is idle: dump_o=1, sel_in_o=0, sel_ref_o=0, busy_o=0, done_o=0, ovr_o=0 and result_o=0.
- R2: While idle, dump_o is high and both selects are low. The cycle in which start_i is high while idle is followed by the integrate phase, so every integrate phase is preceded by at least one discharge cycle.
- R3: In the integrate phase, sel_in_o is high for exactly 2^N consecutive cycles, and sel_ref_o and dump_o are low.
- R4: After the integrate phase, sel_ref_o is high and dump_o is low for the whole de-integrate phase. sel_in_o and sel_ref_o are never high together.
- R5: cmp_i high means the integrator is above zero. result_o equals k, the number of reference-phase clock edges after which cmp_i is first low. The two synchroniser cycles are removed from the count.
- R6: done_o is a single-cycle pulse issued together with each new result_o/ovr_o. Outside that pulse, result_o is stable.
- R7: If cmp_i is still high after 2^N reference clocks (k ≥ 2^N), the conversion ends with ovr_o=1 and result_o set to all ones. Otherwise ovr_o=0.
- R8: start_i is ignored while busy_o is high. A conversion with stray start pulses produces one done pulse and the same result as without them.
- R9: If cmp_i is already low when the reference phase begins (zero input), result_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, honoured only while idle |
| cmp_i | input | 1 | Comparator: high while integrator output is above zero |
| sel_in_o | output | 1 | Connects the integrator to the input voltage |
| sel_ref_o | output | 1 | Connects the integrator to the reference |
| dump_o | output | 1 | Discharges the integrator capacitor |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle pulse with each new result |
| ovr_o | output | 1 | Last conversion overran the reference phase |
| result_o | output | RES_W | Latched conversion result |

## Verification
The hardest cases to reach are the edges of the de-integrate window. One is a crossing on the very last legal reference clock, which must still count as valid even though the synchroniser reports it two cycles later. The other is a crossing one clock later, which must be flagged as overrange. Zero input, where the comparator is already low when the reference phase starts, must give 0 and not wrap below zero. A behavioural integrator in the bench accumulates the input level once per integrate clock and removes the reference level once per reference clock. Scaling the input level against the reference places the crossing at any chosen count, including 255, 256 and 0.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_INTEG = 2'd1,
    ST_DEINT = 2'd2
  } dsc_state_e;
endpackage

// File: rtl/dsc_sync.sv
module dsc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/dsc_counter.sv
module dsc_counter #(
  parameter int W = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (en_i)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/dsc_fsm.sv
module dsc_fsm
  import dsc_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = RES_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             zero_i,
  input  logic [CW-1:0]    cnt_i,
  output dsc_state_e       state_o,
  output logic             cnt_clr_o,
  output logic             cnt_en_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o,
  output logic             ovr_o
);
  // last count at which a delayed crossing is still in range
  localparam int unsigned  TMO_I  = (2**RES_W) - 1 + SYNC_STAGES;
  localparam logic [CW-1:0] TMO   = CW'(TMO_I);
  localparam logic [CW-1:0] SYNC_C = CW'(SYNC_STAGES);

  dsc_state_e       state_q, state_d;
  logic             fin_ok, fin_ovr;
  logic [CW-1:0]    comp_cnt;

  assign comp_cnt = (cnt_i > SYNC_C) ? (cnt_i - SYNC_C) : '0;

  always_comb begin
    state_d   = state_q;
    cnt_clr_o = 1'b0;
    cnt_en_o  = 1'b0;
    fin_ok    = 1'b0;
    fin_ovr   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        cnt_clr_o = 1'b1;
        if (start_i) state_d = ST_INTEG;
      end
      ST_INTEG: begin
        if (&cnt_i[RES_W-1:0]) begin
          cnt_clr_o = 1'b1;
          state_d   = ST_DEINT;
        end else begin
          cnt_en_o = 1'b1;
        end
      end
      ST_DEINT: begin
        cnt_en_o = 1'b1;
        if (zero_i) begin
          fin_ok  = 1'b1;
          state_d = ST_IDLE;
        end else if (cnt_i == TMO) begin
          fin_ovr = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      result_o <= '0;
      done_o   <= 1'b0;
      ovr_o    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= fin_ok | fin_ovr;
      if (fin_ok) begin
        result_o <= comp_cnt[RES_W-1:0];
        ovr_o    <= 1'b0;
      end else if (fin_ovr) begin
        result_o <= '1;
        ovr_o    <= 1'b1;
      end
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
  import dsc_pkg::*;
#(
  parameter int RES_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             cmp_i,
  output logic             sel_in_o,
  output logic             sel_ref_o,
  output logic             dump_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ovr_o,
  output logic [RES_W-1:0] result_o
);
  localparam int CW = RES_W + 1;

  logic          cmp_s;
  logic          cnt_clr, cnt_en;
  logic [CW-1:0] cnt;
  dsc_state_e    state;

  dsc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cmp_i),
    .q_o   (cmp_s)
  );

  dsc_counter #(.W(CW)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .en_i  (cnt_en),
    .cnt_o (cnt)
  );

  dsc_fsm #(.RES_W(RES_W), .SYNC_STAGES(SYNC_STAGES)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .zero_i   (~cmp_s),
    .cnt_i    (cnt),
    .state_o  (state),
    .cnt_clr_o(cnt_clr),
    .cnt_en_o (cnt_en),
    .result_o (result_o),
    .done_o   (done_o),
    .ovr_o    (ovr_o)
  );

  assign sel_in_o  = (state == ST_INTEG);
  assign sel_ref_o = (state == ST_DEINT);
  assign dump_o    = (state == ST_IDLE);
  assign busy_o    = (state != ST_IDLE);
endmodule

// File: rtl/dual_slope_ctrl_chk.sv
module dual_slope_ctrl_chk #(
  parameter int RES_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sel_in_o,
  input logic             sel_ref_o,
  input logic             dump_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             ovr_o,
  input logic [RES_W-1:0] result_o
);
  localparam int unsigned PH1_LEN = 2**RES_W;

  int unsigned in_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       in_run_q <= 0;
    else if (sel_in_o) in_run_q <= in_run_q + 1;
    else               in_run_q <= 0;
  end

  p_sel_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_in_o && sel_ref_o));
  p_dump_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dump_o |-> (!sel_in_o && !sel_ref_o && !busy_o));
  p_dump_first_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sel_in_o) |-> $past(dump_o));
  p_integ_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_in_o) |-> (in_run_q == PH1_LEN));
  p_ref_after_in_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sel_in_o) |-> sel_ref_o);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_result_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(ovr_o)));
  p_ovr_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ovr_o) |-> (&result_o));
endmodule

bind dual_slope_ctrl dual_slope_ctrl_chk #(.RES_W(RES_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_in_o (sel_in_o),
  .sel_ref_o(sel_ref_o),
  .dump_o   (dump_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .ovr_o    (ovr_o),
  .result_o (result_o)
);

// File: tb/dual_slope_ctrl_tb.sv
`timescale 1ns/1ps
module dual_slope_ctrl_tb;
  localparam int RES_W = 8;
  localparam int FULL  = 2**RES_W;
  localparam int VREF  = 1000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic cmp_i;
  logic sel_in_o, sel_ref_o, dump_o, busy_o, done_o, ovr_o;
  logic [RES_W-1:0] result_o;

  int checks = 0;
  int failures = 0;
  int vin = 0;
  longint integ;

  always #4 clk = ~clk;

  dual_slope_ctrl #(.RES_W(RES_W), .SYNC_STAGES(2)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .cmp_i(cmp_i),
    .sel_in_o(sel_in_o), .sel_ref_o(sel_ref_o), .dump_o(dump_o),
    .busy_o(busy_o), .done_o(done_o), .ovr_o(ovr_o), .result_o(result_o)
  );

  // behavioural integrator
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)        integ <= 0;
    else if (dump_o)    integ <= 0;
    else if (sel_in_o)  integ <= integ + vin;
    else if (sel_ref_o) integ <= integ - VREF;
  end
  assign cmp_i = (integ > 0);

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "dump_o", dump_o, 1);
    check("R1", "sel_in_o", sel_in_o, 0);
    check("R1", "sel_ref_o", sel_ref_o, 0);
    check("R1", "busy_o", busy_o, 0);
    check("R1", "done_o", done_o, 0);
    check("R1", "ovr_o", ovr_o, 0);
    check("R1", "result_o", result_o, 0);
  endtask

  task automatic t_convert(input int v, input bit inject, input string req);
    int n_in = 0, n_ref = 0, n_done = 0, n_both = 0, guard = 0;
    int k, exp_res, exp_ovr;
    logic [RES_W-1:0] got_res;
    logic got_ovr = 1'b0;
    got_res = '0;
    k = (FULL * v + VREF - 1) / VREF;
    exp_ovr = (k >= FULL) ? 1 : 0;
    exp_res = exp_ovr ? FULL - 1 : k;
    vin = v;
    @(negedge clk);
    check("R2", "dump_o idle", dump_o, 1);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check("R2", "busy_o after start", busy_o, 1);
    while (n_done == 0 && guard < 3000) begin
      if (sel_in_o) n_in++;
      if (sel_ref_o) n_ref++;
      if (sel_in_o && sel_ref_o) n_both++;
      if (sel_ref_o && dump_o) n_both++;
      start_i = inject && ((sel_in_o && n_in == 10) || (sel_ref_o && n_ref == 3));
      @(negedge clk);
      guard++;
      if (done_o) begin
        n_done++;
        got_res = result_o;
        got_ovr = ovr_o;
      end
    end
    start_i = 1'b0;
    check(req, "conversion finished", n_done, 1);
    check("R3", "integrate cycles", n_in, FULL);
    check("R4", "overlap/dump cycles", n_both, 0);
    check(req, "result_o", got_res, exp_res);
    check("R7", "ovr_o", got_ovr, exp_ovr);
    @(negedge clk);
    check("R6", "done_o one cycle", done_o, 0);
    check("R6", "result held", result_o, exp_res);
    check("R8", "idle after done", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_convert(500, 1'b0, "R5");
    t_convert(250, 1'b0, "R5");
    t_convert(1, 1'b0, "R5");
    t_convert(995, 1'b0, "R5");    // crossing on last legal clock
    t_convert(0, 1'b0, "R9");
    t_convert(1000, 1'b0, "R7");   // one clock beyond range
    t_convert(3000, 1'b0, "R7");
    t_convert(730, 1'b1, "R8");    // stray starts while busy
    t_convert(500, 1'b0, "R5");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule